// File: doc/BRIEF.md
# Page-Bounded Sequential Line Prefetcher

This block watches the stream of demand accesses reaching a cache, given as line addresses, and recognises when consecutive demands climb one line at a time. Once such an ascending run is recognised, it requests the lines just above the latest demand from the memory side. This lets a background fill finish before the demand stream reaches those lines. The distance it may run ahead is set by a parameter. Requests go out through a valid/ready handshake and are held stable while the memory side stalls.

The block never crosses a 4 KB page. A page holds 64 lines of 64 bytes, so the low six bits of a line address give the position inside its page. When the request window reaches the last line of a page, the block stalls. It only restarts after the demand stream steps onto the first line of the following page. Demands that jump about, repeat a line or walk downwards never form a run, so they cost no memory bandwidth. Two counters report how many requests were accepted and how many times a run stalled at a page end.

Top module: `pfs_prefetch`

## Requirements
- R1: While `rst` is high and after it is released, `pf_valid` is low, both counters read zero and no run is active until demands form one.
- R2: A run is confirmed when a demand's line equals the previous demand's line plus one. Any other demand (same line, lower line, or a jump) drops the run. No request is made while no run is confirmed, so random or descending demands produce no requests.
- R3: While a run is confirmed, requests are offered in ascending order starting one line above the latest demand, one per accepted handshake. The first request is visible after the second rising edge following the demand that confirms the run.
- R4: A line L is offered only if L is above the latest demand line D and L − D ≤ `PF_DIST`.
- R5: A line address's bits [`PG_OFF_W`−1:0] (six bits by default) index a line inside a 4 KB page, and the remaining upper bits name the page. A new request always lies in the same page as the latest demand when it is loaded.
- R6: After the last line of a page has been requested, requests stop. They restart only when a demand lands on offset 0 of the next page as the adjacent successor, and they restart at offset 1 of that page. Offset 0 of a page is never requested within a run.
- R7: Within one run, no line is requested twice, and no line at or below a line already demanded is requested.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` keeps its value on the next cycle.
- R9: `pf_issued_cnt` counts the rising edges at which `pf_valid` and `pf_ready` are both high, and wraps modulo 2^`CNT_W`.
- R10: `pf_halt_cnt` increases by exactly one each time a run stalls at a page end. It does not increase again for further demands inside the same stalled page.
- R11: With `TRAIN_HITS` = 1 (the default), demands flagged as hits (`dmd_hit` = 1) and misses train the detector identically. With `TRAIN_HITS` = 0, demands flagged as hits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dmd_valid | input | 1 | A demand access is presented this cycle |
| dmd_line | input | LINE_AW | Line address of the demand access |
| dmd_hit | input | 1 | 1 when the demand hit the cache, 0 on a miss |
| pf_ready | input | 1 | Memory side accepts the current request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | LINE_AW | Line address of the offered request |
| pf_issued_cnt | output | CNT_W | Number of accepted prefetch requests |
| pf_halt_cnt | output | CNT_W | Number of page-end stalls |

## Verification
The bench sweeps an ascending run of eight demands over all 64 starting offsets of a page, with hit and miss flags alternating. Runs that start early in the page test the window limit and the steady ascending order. Runs that start near the end test the page stall, the restart at offset 1 of the next page and the stall counter. A pseudo-random sequence and a descending walk show that non-adjacent patterns issue nothing. Back-to-back demands show that requests overlapping the demand stream are never repeated. A stalled memory side shows the first-request latency, the held request, and the full window drained once it accepts again.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // Training state of the run detector
  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,  // no confirmed run
    TR_RUN  = 2'd1,  // confirmed run, next line still inside the page
    TR_HALT = 2'd2   // confirmed run, next line lies past the page end
  } tr_state_e;

  // log2 of lines per 4 KB page with 64-byte lines
  localparam int unsigned DEF_PG_OFF_W = 6;
endpackage

// File: rtl/pfs_train.sv
module pfs_train
  import pfs_pkg::*;
#(
  parameter int unsigned LINE_AW    = 20,
  parameter int unsigned PG_OFF_W   = DEF_PG_OFF_W,
  parameter int unsigned PF_DIST    = 4,
  parameter bit          TRAIN_HITS = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dmd_valid,
  input  logic [LINE_AW-1:0] dmd_line,
  input  logic               dmd_hit,
  input  logic               adv,        // candidate taken this cycle
  output logic               cand_ok,
  output logic [LINE_AW-1:0] cand_line,
  output logic [LINE_AW-1:0] cur_line,
  output logic               stream_on,
  output logic               halt_evt
);
  localparam logic [LINE_AW-1:0] ONE_L  = LINE_AW'(1);
  localparam logic [LINE_AW-1:0] DIST_L = LINE_AW'(PF_DIST);

  tr_state_e          st_q, st_n;
  logic [LINE_AW-1:0] last_q, last_n;
  logic [LINE_AW-1:0] nxt_q, nxt_n, base;
  logic               have_q, have_n;
  logic               train, adj, conf_n;

  always_comb begin
    train  = dmd_valid && (TRAIN_HITS || !dmd_hit);
    base   = adv ? nxt_q + ONE_L : nxt_q;
    adj    = have_q && (dmd_line == last_q + ONE_L);
    last_n = last_q;
    have_n = have_q;
    nxt_n  = base;
    conf_n = (st_q != TR_IDLE);
    if (train) begin
      last_n = dmd_line;
      have_n = 1'b1;
      conf_n = adj;
      nxt_n  = (adj && (base > dmd_line)) ? base : dmd_line + ONE_L;
    end
    if (!conf_n)
      st_n = TR_IDLE;
    else if (nxt_n[LINE_AW-1:PG_OFF_W] != last_n[LINE_AW-1:PG_OFF_W])
      st_n = TR_HALT;
    else
      st_n = TR_RUN;
    halt_evt = (st_n == TR_HALT) && (st_q != TR_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TR_IDLE;
      last_q <= '0;
      nxt_q  <= '0;
      have_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      last_q <= last_n;
      nxt_q  <= nxt_n;
      have_q <= have_n;
    end
  end

  assign cand_ok   = (st_q == TR_RUN) && ((nxt_q - last_q) <= DIST_L);
  assign cand_line = nxt_q;
  assign cur_line  = last_q;
  assign stream_on = (st_q != TR_IDLE);

  // R6
  resume_at_page_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == TR_HALT) && (st_q == TR_RUN) |-> (last_q[PG_OFF_W-1:0] == '0));
endmodule

// File: rtl/pfs_issue.sv
module pfs_issue #(
  parameter int unsigned LINE_AW = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cand_ok,
  input  logic [LINE_AW-1:0] cand_line,
  input  logic               pf_ready,
  output logic               pf_valid,
  output logic [LINE_AW-1:0] pf_line,
  output logic               adv
);
  logic               v_q;
  logic [LINE_AW-1:0] line_q;
  logic               slot_free;

  assign slot_free = !v_q || pf_ready;
  assign adv       = slot_free && cand_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      line_q <= '0;
    end else if (slot_free) begin
      v_q <= cand_ok;
      if (cand_ok) line_q <= cand_line;
    end
  end

  assign pf_valid = v_q;
  assign pf_line  = line_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));
endmodule

// File: rtl/pfs_evcnt.sv
module pfs_evcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pfs_prefetch.sv
module pfs_prefetch
  import pfs_pkg::*;
#(
  parameter int unsigned LINE_AW    = 20,
  parameter int unsigned PG_OFF_W   = DEF_PG_OFF_W,
  parameter int unsigned PF_DIST    = 4,
  parameter int unsigned CNT_W      = 16,
  parameter bit          TRAIN_HITS = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dmd_valid,
  input  logic [LINE_AW-1:0] dmd_line,
  input  logic               dmd_hit,
  input  logic               pf_ready,
  output logic               pf_valid,
  output logic [LINE_AW-1:0] pf_line,
  output logic [CNT_W-1:0]   pf_issued_cnt,
  output logic [CNT_W-1:0]   pf_halt_cnt
);
  localparam int unsigned NUM_EV = 2;
  localparam logic [LINE_AW-1:0] DIST_L = LINE_AW'(PF_DIST);

  logic               cand_ok, adv, stream_on, halt_evt;
  logic [LINE_AW-1:0] cand_line, cur_line;

  pfs_train #(
    .LINE_AW(LINE_AW), .PG_OFF_W(PG_OFF_W),
    .PF_DIST(PF_DIST), .TRAIN_HITS(TRAIN_HITS)
  ) u_train (
    .clk(clk), .rst(rst),
    .dmd_valid(dmd_valid), .dmd_line(dmd_line), .dmd_hit(dmd_hit),
    .adv(adv), .cand_ok(cand_ok), .cand_line(cand_line),
    .cur_line(cur_line), .stream_on(stream_on), .halt_evt(halt_evt)
  );

  pfs_issue #(.LINE_AW(LINE_AW)) u_issue (
    .clk(clk), .rst(rst),
    .cand_ok(cand_ok), .cand_line(cand_line),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line),
    .adv(adv)
  );

  logic [NUM_EV-1:0] ev_inc;
  logic [CNT_W-1:0]  ev_cnt [NUM_EV];
  assign ev_inc = {halt_evt, pf_valid & pf_ready};

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_cnt
    pfs_evcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(ev_inc[gi]), .cnt(ev_cnt[gi])
    );
  end

  assign pf_issued_cnt = ev_cnt[0];
  assign pf_halt_cnt   = ev_cnt[1];

  // R2
  no_run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !stream_on && !pf_valid |=> !pf_valid);

  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid && (!$past(pf_valid) || $past(pf_ready))
    |-> pf_line[LINE_AW-1:PG_OFF_W] == $past(cur_line[LINE_AW-1:PG_OFF_W]));

  // R4
  window_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid && (!$past(pf_valid) || $past(pf_ready))
    |-> (pf_line > $past(cur_line)) && ((pf_line - $past(cur_line)) <= DIST_L));
endmodule

// File: tb/pfs_prefetch_tb_top.sv
module pfs_prefetch_tb_top;
  localparam int AW   = 20;
  localparam int DIST = 4;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          dmd_valid = 1'b0;
  logic [AW-1:0] dmd_line  = '0;
  logic          dmd_hit   = 1'b0;
  logic          pf_ready  = 1'b1;
  logic          pf_valid;
  logic [AW-1:0] pf_line;
  logic [CW-1:0] pf_issued_cnt, pf_halt_cnt;

  pfs_prefetch #(.LINE_AW(AW), .PF_DIST(DIST), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst),
    .dmd_valid(dmd_valid), .dmd_line(dmd_line), .dmd_hit(dmd_hit),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line),
    .pf_issued_cnt(pf_issued_cnt), .pf_halt_cnt(pf_halt_cnt)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int obs[$];
  int exp_q[$];
  int exp_issued = 0, exp_halts = 0;

  // record accepted requests away from the clock edges
  always begin
    @(negedge clk);
    #1;
    if (!rst && pf_valid && pf_ready) obs.push_back(int'(pf_line));
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic demand(input int line, input bit hit);
    dmd_valid = 1'b1;
    dmd_line  = AW'(line);
    dmd_hit   = hit;
    @(negedge clk);
    dmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare_obs(input string req);
    int bad = -1;
    chk(obs.size() == exp_q.size(), {req, " count"}, obs.size(), exp_q.size());
    for (int i = 0; i < obs.size() && i < exp_q.size(); i++)
      if (bad < 0 && obs[i] != exp_q[i]) bad = i;
    chk(bad < 0, {req, " lines"}, (bad >= 0) ? obs[bad] : 0, (bad >= 0) ? exp_q[bad] : 0);
    exp_issued += obs.size();
    obs.delete();
    exp_q.delete();
  endtask

  task automatic check_counters(input string tag);
    chk(int'(pf_issued_cnt) == exp_issued, {"R9 issued counter ", tag}, int'(pf_issued_cnt), exp_issued);
    chk(int'(pf_halt_cnt) == exp_halts, {"R10 stall counter ", tag}, int'(pf_halt_cnt), exp_halts);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pf_valid == 1'b0, "R1 valid in reset", int'(pf_valid), 0);
    rst = 1'b0;
    idle(2);
    chk(pf_valid == 1'b0, "R1 valid after reset", int'(pf_valid), 0);
    chk(pf_issued_cnt == '0, "R1 issued counter", int'(pf_issued_cnt), 0);
    chk(pf_halt_cnt == '0, "R1 stall counter", int'(pf_halt_cnt), 0);

    // Sweep: 8-line ascending run from every offset of a page, hits alternating (R11)
    for (int s = 0; s < 64; s++) begin
      int a;
      int hw;
      bit h;
      a  = (8 + s) * 64 + s;
      hw = a + 1;
      h  = 1'b0;
      demand(a, (s % 2) == 1);
      idle(8);
      for (int i = 1; i < 8; i++) begin
        int d, pe, lim, st;
        bit hn;
        d = a + i;
        demand(d, ((s + i) % 2) == 1);
        idle(8);
        pe  = d | 63;
        lim = (d + DIST < pe) ? d + DIST : pe;
        st  = ((hw > d) ? hw : d) + 1;
        for (int x = st; x <= lim; x++) exp_q.push_back(x);
        if (lim > hw) hw = lim;
        hn = (d + DIST >= pe);
        if (hn && !h) exp_halts++;
        h = hn;
      end
      compare_obs("R3 R4 R5 R6 R7 R11 sweep");
      check_counters("sweep");
    end

    // Pseudo-random, never adjacent: no requests (R2)
    begin
      logic [15:0] r;
      int prev;
      r = 16'hACE1;
      prev = -5;
      for (int k = 0; k < 40; k++) begin
        int x;
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        x = 300 * 64 + int'(r[11:0]);
        if (x == prev + 1) x = x + 2;
        demand(x, r[0]);
        idle(2);
        prev = x;
      end
      idle(10);
      compare_obs("R2 random pattern");
    end

    // Descending walk: no requests (R2)
    for (int k = 0; k < 10; k++) begin
      demand(500 * 64 + 40 - k, 1'b0);
      idle(3);
    end
    idle(10);
    compare_obs("R2 descending pattern");
    check_counters("after non-runs");

    // Back-to-back demands overlapping requests (R7)
    begin
      int b;
      b = 600 * 64 + 10;
      for (int k = 0; k < 6; k++) demand(b + k, 1'b0);
      idle(12);
      for (int x = b + 2; x <= b + 5 + DIST; x++) exp_q.push_back(x);
      compare_obs("R7 back-to-back");
    end

    // Stalled memory side (R3 latency, R8 hold, R4 window on release)
    begin
      int c;
      c = 700 * 64 + 20;
      pf_ready = 1'b0;
      idle(2);
      demand(c, 1'b0);
      demand(c + 1, 1'b1);
      chk(pf_valid == 1'b0, "R3 not yet offered", int'(pf_valid), 0);
      @(negedge clk);
      chk(pf_valid == 1'b1, "R3 first request valid", int'(pf_valid), 1);
      chk(int'(pf_line) == c + 2, "R3 first request line", int'(pf_line), c + 2);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(pf_valid == 1'b1 && int'(pf_line) == c + 2, "R8 held request", int'(pf_line), c + 2);
      end
      chk(obs.size() == 0, "R8 nothing accepted while stalled", obs.size(), 0);
      pf_ready = 1'b1;
      idle(10);
      for (int x = c + 2; x <= c + 1 + DIST; x++) exp_q.push_back(x);
      compare_obs("R4 R8 release");
    end
    check_counters("final");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule